// File: doc/BRIEF.md
# Serial Memory Slave over SPI

This block is the device side of a small serial memory reached over SPI in modes 0 and 3. A host lowers chip select, clocks in an 8-bit command and, depending on the command, a 16-bit address and data bytes, and raises chip select to close the frame. The block keeps a byte array, a separate 64-byte identification page and a one-byte status register. A status flag chooses which of the two stores reads and writes reach. Writes are gated by a write-enable latch, by a write-protect pin and by a lock bit. A hold input pauses a transfer without losing its place.

All SPI pins are sampled in the system clock domain, which must run at least eight times faster than the serial clock. Edges on the serial clock are found from these samples. Data writes are collected during the frame and reach the array only when chip select rises on a byte boundary. Reads stream from the array while the host keeps clocking.

Top module: `ser_mem_slave`

## Requirements
- R1: Serial input is captured on a rising serial-clock edge and serial output changes on a falling edge. Frames work with the clock idling low (mode 0) or high (mode 3).
- R2: While chip select is high, `miso_oe` is low and `miso` is 0. A falling chip select starts a new frame at the command byte, and a rising chip select abandons any frame in progress.
- R3: The command values are 0x06 (set write enable), 0x04 (clear write enable), 0x05 (read status), 0x01 (write status), 0x03 (read data) and 0x02 (write data). Any other first byte makes the rest of the frame have no effect, and `miso` stays 0 for that frame.
- R4: The status byte reads as bit 7 lock (WPEN), bit 6 page select, bit 1 write-enable latch, with all other bits 0. A write-data or write-status frame whose command arrives with the latch clear has no effect.
- R5: A write-status command arriving while `wp_n` is low and the lock bit is 1 has no effect. With `wp_n` high it is accepted.
- R6: Lowering `hold_n` while the serial clock is low pauses the frame, drops `miso_oe` and makes serial-clock edges have no effect. Raising `hold_n` while the clock is low resumes the frame where it stopped.
- R7: A read-data frame takes a 16-bit address, MSB first, then returns bytes MSB first from consecutive addresses.
- R8: Main-array addresses use the low ADDR_W bits of the address and wrap from the last byte to byte 0.
- R9: With the page-select bit at 1, reads and writes reach the 64-byte identification page and use the low 6 address bits. With the bit at 0 they reach the main array.
- R10: The write-enable latch clears when a write-data or write-status frame commits.
- R11: A write-data or write-status frame commits only if chip select rises on a byte boundary after at least one data byte. Otherwise the frame is discarded and the latch is kept.
- R12: A write-data frame stores at most BUF_N bytes (default 4), and later bytes are ignored. A write-status frame uses only its first data byte, and only bits 7 and 6 of that byte.
- R13: After reset the status byte is 0x00, every array and page byte is 0x00 and `miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect, active low |
| miso | output | 1 | Serial data out, 0 when not enabled |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |

## Verification
The assertions assume that the SPI pins change no faster than the system clock can sample them. They also assume that `hold_n` changes only while the serial clock is low, and that chip select moves only while the serial clock is at its idle level. The bench drives every pin on the falling system-clock edge and holds each serial-clock level for four system cycles. It toggles `hold_n` only after a falling serial edge, and it raises chip select only after the closing clock level of a bit. Under those limits the checks can state that output enable follows chip select and hold, that the status bits move only under the latch, and that commits happen only at a byte-aligned frame end.

// File: rtl/ser_mem_pkg.sv
// Shared command codes, status bit positions and frame phases for the
// serial memory slave. Assumes an 8-bit command byte, MSB first.
package ser_mem_pkg;
    localparam logic [7:0] CMD_WEN_SET = 8'h06;
    localparam logic [7:0] CMD_WEN_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD = 8'h05;
    localparam logic [7:0] CMD_STAT_WR = 8'h01;
    localparam logic [7:0] CMD_DATA_RD = 8'h03;
    localparam logic [7:0] CMD_DATA_WR = 8'h02;

    typedef enum logic [2:0] {
        PH_CMD,    // waiting for the command byte
        PH_ADDR,   // shifting in two address bytes
        PH_RDATA,  // streaming array bytes out
        PH_WDATA,  // collecting bytes to write
        PH_STAT,   // streaming the status byte out
        PH_SRIN,   // collecting the status byte to write
        PH_SKIP    // rest of frame has no effect
    } phase_t;
endpackage

// File: rtl/ser_pin_sync.sv
// Samples the SPI pins in the system clock domain and turns them into
// single-cycle edge strobes. Serial-clock edges are masked while chip select
// is high or while a hold pause is active. Assumes the pins are slow
// against clk (at least 8 clk cycles per serial clock period).
module ser_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic hold_n,
    output logic cs_idle,
    output logic cs_end,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic held
);
    logic cs_d, sck_s, sck_d, hold_s, hold_d;

    // Sample pins and keep the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_idle <= 1'b1;
            cs_d    <= 1'b1;
            sck_s   <= 1'b0;
            sck_d   <= 1'b0;
            mosi_s  <= 1'b0;
            hold_s  <= 1'b1;
            hold_d  <= 1'b1;
        end else begin
            cs_idle <= cs_n;
            cs_d    <= cs_idle;
            sck_s   <= sck;
            sck_d   <= sck_s;
            mosi_s  <= mosi;
            hold_s  <= hold_n;
            hold_d  <= hold_s;
        end
    end

    // Track the pause: hold edges count only while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle)
            held <= 1'b0;
        else if (hold_d && !hold_s && !sck_s)
            held <= 1'b1;
        else if (!hold_d && hold_s && !sck_s)
            held <= 1'b0;
    end

    assign cs_end   = cs_idle && !cs_d;
    assign sck_rise = sck_s && !sck_d && !cs_idle && !held;
    assign sck_fall = !sck_s && sck_d && !cs_idle && !held;
endmodule

// File: rtl/ser_status.sv
// Status register: write-enable latch, lock bit and page-select bit.
// Setting the latch wins over clearing it; cs framing keeps them apart.
module ser_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_set,
    input  logic       wel_clr,
    input  logic       load,
    input  logic       ld_lock,
    input  logic       ld_page,
    output logic       wel,
    output logic       lock,
    output logic       page,
    output logic [7:0] sr_byte
);
    // Latch follows the set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (wel_set) wel <= 1'b1;
        else if (wel_clr) wel <= 1'b0;
    end

    // Lock and page bits load on a committed status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
            page <= 1'b0;
        end else if (load) begin
            lock <= ld_lock;
            page <= ld_page;
        end
    end

    assign sr_byte = {lock, page, 4'b0000, wel, 1'b0};
endmodule

// File: rtl/ser_mem_store.sv
// Main byte array plus a 2**ID_W byte identification page. Reads are
// combinational; a commit writes up to BUF_N staged bytes at consecutive
// wrapped addresses in one clk cycle. Assumes ADDR_W >= ID_W.
module ser_mem_store #(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 6,
    parameter int BUF_N  = 4,
    parameter int NB_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  use_id,
    output logic [7:0]            rd_byte,
    input  logic                  wr_go,
    input  logic [ADDR_W-1:0]     wr_base,
    input  logic [NB_W-1:0]       wr_cnt,
    input  logic [BUF_N-1:0][7:0] wr_data
);
    localparam int MAIN_N = 1 << ADDR_W;
    localparam int ID_N   = 1 << ID_W;

    logic [7:0]        main_q [MAIN_N];
    logic [7:0]        id_q   [ID_N];
    logic [ADDR_W-1:0] slot_a [BUF_N];

    // One wrapped target address per staging slot.
    for (genvar g = 0; g < BUF_N; g++) begin : g_slot
        assign slot_a[g] = wr_base + ADDR_W'(g);
    end

    // Reset both stores, then apply committed slots to the selected one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAIN_N; i++) main_q[i] <= 8'h00;
            for (int i = 0; i < ID_N; i++)   id_q[i]   <= 8'h00;
        end else if (wr_go) begin
            for (int i = 0; i < BUF_N; i++) begin
                if (i < int'(wr_cnt)) begin
                    if (use_id) id_q[slot_a[i][ID_W-1:0]] <= wr_data[i];
                    else        main_q[slot_a[i]]         <= wr_data[i];
                end
            end
        end
    end

    assign rd_byte = use_id ? id_q[rd_addr[ID_W-1:0]] : main_q[rd_addr];
endmodule

// File: rtl/ser_mem_slave.sv
// Top of the serial memory slave: frames commands over SPI modes 0 and 3,
// gates writes by latch, protect pin and lock bit, and drives the serial
// output with an enable. Assumes pins are oversampled by clk (see sync).
module ser_mem_slave #(
    parameter int ADDR_W = 8,
    parameter int BUF_N  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic hold_n,
    input  logic wp_n,
    output logic miso,
    output logic miso_oe
);
    import ser_mem_pkg::*;

    localparam int ID_W  = 6;
    localparam int NB_W  = $clog2(BUF_N + 1);
    localparam int IDX_W = $clog2(BUF_N);
    localparam logic [NB_W-1:0] NB_MAX = NB_W'(BUF_N);

    logic cs_idle, cs_end, sck_rise, sck_fall, mosi_s, held;
    logic wel, lock, page;
    logic [7:0] sr_byte, rd_byte, full_byte;

    phase_t            phase;
    logic [2:0]        bcnt;
    logic [6:0]        rx;
    logic [ADDR_W-1:0] addr;
    logic              abyte, is_rd, sr_have, miso_q;
    logic [1:0]        sr_pend;
    logic [NB_W-1:0]   nbuf;
    logic [BUF_N-1:0][7:0] wbuf;

    logic byte_done, wel_set, wel_clr, commit_wr, commit_sr, sr_ok;

    ser_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .cs_idle(cs_idle), .cs_end(cs_end),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .held(held)
    );

    ser_status u_stat (
        .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .load(commit_sr), .ld_lock(sr_pend[1]), .ld_page(sr_pend[0]),
        .wel(wel), .lock(lock), .page(page), .sr_byte(sr_byte)
    );

    ser_mem_store #(.ADDR_W(ADDR_W), .ID_W(ID_W), .BUF_N(BUF_N), .NB_W(NB_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .use_id(page),
        .rd_byte(rd_byte), .wr_go(commit_wr), .wr_base(addr),
        .wr_cnt(nbuf), .wr_data(wbuf)
    );

    assign full_byte = {rx, mosi_s};
    assign byte_done = sck_rise && (bcnt == 3'd7);
    assign sr_ok     = wel && !(lock && !wp_n);
    assign wel_set   = byte_done && phase == PH_CMD && full_byte == CMD_WEN_SET;
    assign commit_wr = cs_end && phase == PH_WDATA && bcnt == 3'd0 && nbuf != '0;
    assign commit_sr = cs_end && phase == PH_SRIN && bcnt == 3'd0 && sr_have;
    assign wel_clr   = (byte_done && phase == PH_CMD && full_byte == CMD_WEN_CLR)
                     || commit_wr || commit_sr;

    // Frame sequencer: bit count, command decode, address and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            phase   <= PH_CMD;
            bcnt    <= 3'd0;
            rx      <= '0;
            addr    <= '0;
            abyte   <= 1'b0;
            is_rd   <= 1'b0;
            nbuf    <= '0;
            sr_have <= 1'b0;
            sr_pend <= 2'b00;
        end else if (sck_rise) begin
            bcnt <= bcnt + 3'd1;
            rx   <= {rx[5:0], mosi_s};
            if (phase == PH_ADDR) addr <= {addr[ADDR_W-2:0], mosi_s};
            if (bcnt == 3'd7) begin
                case (phase)
                    PH_CMD: begin
                        case (full_byte)
                            CMD_STAT_RD: phase <= PH_STAT;
                            CMD_STAT_WR: phase <= sr_ok ? PH_SRIN : PH_SKIP;
                            CMD_DATA_RD: begin
                                phase <= PH_ADDR;
                                is_rd <= 1'b1;
                            end
                            CMD_DATA_WR: phase <= wel ? PH_ADDR : PH_SKIP;
                            default:     phase <= PH_SKIP;
                        endcase
                    end
                    PH_ADDR: begin
                        abyte <= 1'b1;
                        if (abyte) phase <= is_rd ? PH_RDATA : PH_WDATA;
                    end
                    PH_RDATA: addr <= addr + ADDR_W'(1);
                    PH_WDATA: begin
                        if (nbuf < NB_MAX) begin
                            wbuf[nbuf[IDX_W-1:0]] <= full_byte;
                            nbuf <= nbuf + NB_W'(1);
                        end
                    end
                    PH_SRIN: begin
                        if (!sr_have) begin
                            sr_pend <= full_byte[7:6];
                            sr_have <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output bit: MSB first, updated on falling serial-clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) miso_q <= 1'b0;
        else if (sck_fall) begin
            case (phase)
                PH_RDATA: miso_q <= rd_byte[~bcnt];
                PH_STAT:  miso_q <= sr_byte[~bcnt];
                default:  miso_q <= 1'b0;
            endcase
        end
    end

    assign miso_oe = !cs_idle && !held;
    assign miso    = miso_oe && miso_q;
endmodule

// File: rtl/ser_mem_slave_chk.sv
// Property checker for ser_mem_slave, attached by bind. Assumes pins
// are driven as in the block's Verification section.
module ser_mem_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       miso_oe,
    input logic       held,
    input logic       wel,
    input logic       lock,
    input logic       page,
    input logic       commit,
    input logic       cs_end,
    input logic [2:0] bcnt
);
    a_r2_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !miso_oe);

    a_r6_hold_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !miso_oe);

    a_r4_status_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({lock, page}) |-> $past(wel));

    a_r10_latch_drops: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wel);

    a_r11_commit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cs_end && bcnt == 3'd0));
endmodule

bind ser_mem_slave ser_mem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
    .held(held), .wel(wel), .lock(lock), .page(page),
    .commit(commit_wr || commit_sr), .cs_end(cs_end), .bcnt(bcnt)
);

// File: tb/test_ser_mem_slave.sv
// Bench: behavioural model of array, page and status bits; frames driven
// bit by bit, every returned byte and the output enable compared.
module test_ser_mem_slave;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    wire  miso, miso_oe;

    always #4 clk = ~clk;

    ser_mem_slave i_ser_mem_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
    );

    localparam int HALF = 4;
    int errs = 0, checks = 0;
    bit mode3 = 1'b0;
    byte unsigned mem_m [256];
    byte unsigned id_m  [64];
    bit wel_m = 0, lock_m = 0, page_m = 0;
    logic [7:0] r;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int sr_m();
        return {24'd0, lock_m, page_m, 4'b0000, wel_m, 1'b0};
    endfunction

    task automatic bit_x(input logic b, output logic q);
        if (mode3) begin
            sck = 1'b0; mosi = b; tick(HALF); q = miso; sck = 1'b1; tick(HALF);
        end else begin
            mosi = b; tick(HALF); q = miso; sck = 1'b1; tick(HALF); sck = 1'b0;
        end
    endtask

    task automatic byte_x(input logic [7:0] v, output logic [7:0] q);
        for (int i = 7; i >= 0; i--) bit_x(v[i], q[i]);
    endtask

    task automatic open_f();
        sck = mode3; tick(2); cs_n = 1'b0; tick(HALF);
    endtask

    task automatic close_f();
        tick(HALF); cs_n = 1'b1; tick(3 * HALF);
    endtask

    task automatic cmd_only(input logic [7:0] op);
        logic [7:0] q;
        open_f(); byte_x(op, q); close_f();
        if (op == 8'h06) wel_m = 1;
        if (op == 8'h04) wel_m = 0;
    endtask

    task automatic stat_rd(input string req);
        logic [7:0] q;
        open_f(); byte_x(8'h05, q); byte_x(8'h00, q); close_f();
        check(req, int'(q), sr_m(), "status byte");
    endtask

    task automatic stat_wr(input logic [7:0] v);
        logic [7:0] q;
        open_f(); byte_x(8'h01, q); byte_x(v, q); close_f();
        if (wel_m && !(lock_m && !wp_n)) begin
            lock_m = v[7]; page_m = v[6]; wel_m = 0;
        end
    endtask

    task automatic data_wr(input int a, input byte unsigned d[$]);
        logic [7:0] q;
        open_f(); byte_x(8'h02, q); byte_x(8'(a >> 8), q); byte_x(8'(a), q);
        foreach (d[i]) byte_x(d[i], q);
        close_f();
        if (wel_m && d.size() > 0) begin
            for (int i = 0; i < d.size() && i < 4; i++) begin
                if (page_m) id_m[(a + i) % 64] = d[i];
                else        mem_m[(a + i) % 256] = d[i];
            end
            wel_m = 0;
        end
    endtask

    task automatic data_rd(input int a, input int n, input string req);
        logic [7:0] q;
        open_f(); byte_x(8'h03, q); byte_x(8'(a >> 8), q); byte_x(8'(a), q);
        for (int i = 0; i < n; i++) begin
            byte_x(8'h00, q);
            check(req, int'(q), page_m ? int'(id_m[(a + i) % 64]) : int'(mem_m[(a + i) % 256]),
                  $sformatf("read byte %0d at %0h", i, a));
        end
        close_f();
    endtask

    // Output-enable monitor: once cs_n and hold_n have settled, enable must match.
    int quiet = 0;
    logic pcs = 1'b1, phold = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n !== pcs || hold_n !== phold) quiet = 0;
            else if (quiet < 10) quiet++;
            pcs = cs_n; phold = hold_n;
            if (quiet >= 3) check("R2/R6", int'(miso_oe), int'(!cs_n && hold_n), "output enable");
            if (cs_n && quiet >= 3) check("R2", int'(miso), 0, "idle output");
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        for (int i = 0; i < 64; i++)  id_m[i]  = 8'h00;
        tick(5); rst_n = 1'b1; tick(3);
        check("R13", int'(miso_oe), 0, "enable after reset");
        stat_rd("R13");
        data_rd(16'h0000, 2, "R13");

        data_wr(16'h0010, '{8'h11, 8'h22});          // R4: latch clear, ignored
        data_rd(16'h0010, 2, "R4");
        cmd_only(8'h06);
        stat_rd("R4");
        data_wr(16'h0010, '{8'hA1, 8'hB2, 8'hC3});
        stat_rd("R10");
        data_rd(16'h0010, 3, "R7");

        cmd_only(8'h06); cmd_only(8'h04);
        stat_rd("R4");
        data_wr(16'h0020, '{8'h55});
        data_rd(16'h0020, 1, "R4");

        cmd_only(8'h06);
        data_wr(16'h00FF, '{8'h5A, 8'h6B});
        data_rd(16'h00FF, 2, "R8");
        data_rd(16'h1210, 1, "R8");

        cmd_only(8'h06);
        data_wr(16'h0040, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06});
        data_rd(16'h0040, 6, "R12");

        // R11: frame cut three bits into a data byte is discarded
        cmd_only(8'h06);
        open_f(); byte_x(8'h02, r); byte_x(8'h00, r); byte_x(8'h50, r);
        byte_x(8'hEE, r);
        for (int i = 0; i < 3; i++) bit_x(1'b1, r[0]);
        close_f();
        stat_rd("R11");
        data_rd(16'h0050, 2, "R11");

        // R3: unknown command, then a byte that would set the latch
        cmd_only(8'h04);
        open_f(); byte_x(8'hAA, r); byte_x(8'h06, r);
        check("R3", int'(r), 0, "output after unknown command");
        close_f();
        stat_rd("R3");

        // R5: lock bit with protect pin
        cmd_only(8'h06); stat_wr(8'h80); stat_rd("R5");
        wp_n = 1'b0;
        cmd_only(8'h06); stat_wr(8'h00); stat_rd("R5");
        wp_n = 1'b1;
        stat_wr(8'h00); stat_rd("R5");

        // R12 and R9: only bits 7..6 load; page select redirects accesses
        cmd_only(8'h06); stat_wr(8'h7F); stat_rd("R12");
        cmd_only(8'h06);
        data_wr(16'h0005, '{8'h77});
        data_rd(16'h0005, 1, "R9");
        data_rd(16'h0045, 1, "R9");
        cmd_only(8'h06); stat_wr(8'h00);
        data_rd(16'h0005, 1, "R9");

        // R6: pause mid-byte during a read, wiggle the clock, resume
        open_f(); byte_x(8'h03, r); byte_x(8'h00, r); byte_x(8'h10, r);
        for (int i = 7; i >= 4; i--) bit_x(1'b0, r[i]);
        hold_n = 1'b0; tick(6);
        check("R6", int'(miso_oe), 0, "enable while paused");
        for (int k = 0; k < 2; k++) begin sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF); end
        hold_n = 1'b1; tick(6);
        check("R6", int'(miso_oe), 1, "enable after resume");
        for (int i = 3; i >= 0; i--) bit_x(1'b0, r[i]);
        check("R6", int'(r), int'(mem_m[8'h10]), "byte across pause");
        close_f();

        // R1: mode 3 frames
        mode3 = 1'b1;
        cmd_only(8'h06);
        stat_rd("R1");
        data_wr(16'h0030, '{8'h3C, 8'hC3});
        data_rd(16'h0030, 2, "R1");
        mode3 = 1'b0;
        data_rd(16'h0031, 1, "R1");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule